// File: doc/BRIEF.md
# Two-Port Burst SRAM with Half-Cycle Staggered Ports

This block is a synthesizable model of a synchronous static memory with two fully independent access ports. Each port can start one read or one write in every clock period, so any mix of reads and writes on the two ports runs at the full transaction rate. Both ports use the same input clock. Port A takes its request on the rising edge and port B on the falling edge half a period later.

Every access moves a fixed burst of two words over a double-data-rate data path, with one word per clock edge. An external address selects a pair of words in the shared array. The burst index is the lowest bit of the internal word address. Read data returns after a parameterized latency together with a valid flag. Write data follows the command after a parameterized delay. When both ports touch the same location in the same period, a fixed ordering decides the result.

Top module: `dp_burst_sram`

## Requirements
- R1: While a port's load strobe (`*_ld_n`) is high at that port's sampling edge, the port issues no operation. No read-valid follows, and the stored contents do not change, whatever the select, address and write data are.
- R2: Port A samples `a_ld_n`, `a_rw_n` and `a_addr` on the rising edge. `a_rw_n` = 1 means read and 0 means write.
- R3: A port-A read sampled at rising edge k drives `a_rvalid` high for the whole period that begins at rising edge k+RD_LAT. `a_rdata` carries word 0 while the clock is high and word 1 while it is low.
- R4: Port B samples its controls and address on the falling edge. A port-B read sampled at falling edge k drives `b_rvalid` high from falling edge k+RD_LAT to the next falling edge. `b_rdata` carries word 0 while the clock is low and word 1 while it is high.
- R5: Port-A write data is taken as follows: word 0 on the rising edge WR_LAT periods after the command, and word 1 on the falling edge that follows it. Port-B write data is taken as follows: word 0 on the falling edge WR_LAT periods after the command, and word 1 on the rising edge that follows it.
- R6: Each external address holds two independent words. Internal word address = {address, burst index}. A read returns exactly the two words last written to that address, in order.
- R7: Both ports are accepted in the same period for every combination of read and write. A read on one port and a write on the other, to different addresses, both complete correctly.
- R8: When both ports write the same address in the same period, both stored words are port B's.
- R9: A read issued in the same period as a write to the same address, on either port, returns the contents from before that write.
- R10: The word width parameter `WORD_W` accepts 18 or 36, and all of its bits are stored and returned.
- R11: An active-low asynchronous reset clears both read-valid outputs. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock. Port A uses the rising edge, port B the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ld_n | input | 1 | Port A load strobe, active low |
| a_rw_n | input | 1 | Port A select: 1 = read, 0 = write |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | WORD_W | Port A write data, DDR |
| a_rdata | output | WORD_W | Port A read data, DDR |
| a_rvalid | output | 1 | Port A read burst in progress |
| b_ld_n | input | 1 | Port B load strobe, active low |
| b_rw_n | input | 1 | Port B select: 1 = read, 0 = write |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | WORD_W | Port B write data, DDR |
| b_rdata | output | WORD_W | Port B read data, DDR |
| b_rvalid | output | 1 | Port B read burst in progress |

## Verification
The bench targets three kinds of fault. It issues same-period writes to one address from both ports; a design that committed port A last would return A's words. It pairs a read with a same-period write to the same address on the other port; a design that bypassed or committed early would return the new data instead of the old. It holds the load strobe high while moving the address, the select and the data; a design that ignored the strobe would produce a spurious valid or corrupt a location. It also checks the phase of each read word, since swapping the edges of the burst order, or of port B's half-cycle offset, shows up as swapped words.

// File: rtl/dp_burst_sram.sv
module dp_burst_sram #(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 6,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_ld_n,
  input  logic              a_rw_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_ld_n,
  input  logic              b_rw_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_rvalid
);
  localparam int DEPTH = 1 << (ADDR_W + 1);

  logic [WORD_W-1:0] mem [DEPTH];

  wire a_rd = !a_ld_n &&  a_rw_n;
  wire a_wr = !a_ld_n && !a_rw_n;
  wire b_rd = !b_ld_n &&  b_rw_n;
  wire b_wr = !b_ld_n && !b_rw_n;

  // write command delay lines
  logic [WR_LAT-1:0] aw_v, bw_v;
  logic [ADDR_W-1:0] aw_a [WR_LAT];
  logic [ADDR_W-1:0] bw_a [WR_LAT];

  // commit staging
  logic              a_cv, b_cv;
  logic [ADDR_W-1:0] a_ca, b_ca;
  logic [WORD_W-1:0] a_d0, a_d1, b_d0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      aw_v <= '0;
      a_cv <= 1'b0;
    end else begin
      aw_v[0] <= a_wr;
      for (int i = 1; i < WR_LAT; i++) aw_v[i] <= aw_v[i-1];
      a_cv <= aw_v[WR_LAT-1];
    end

  always_ff @(posedge clk) begin
    aw_a[0] <= a_addr;
    for (int i = 1; i < WR_LAT; i++) aw_a[i] <= aw_a[i-1];
    a_ca <= aw_a[WR_LAT-1];
    a_d0 <= a_wdata;
  end

  always_ff @(negedge clk) a_d1 <= a_wdata;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      bw_v <= '0;
      b_cv <= 1'b0;
    end else begin
      bw_v[0] <= b_wr;
      for (int i = 1; i < WR_LAT; i++) bw_v[i] <= bw_v[i-1];
      b_cv <= bw_v[WR_LAT-1];
    end

  always_ff @(negedge clk) begin
    bw_a[0] <= b_addr;
    for (int i = 1; i < WR_LAT; i++) bw_a[i] <= bw_a[i-1];
    b_ca <= bw_a[WR_LAT-1];
    b_d0 <= b_wdata;
  end

  // both ports commit on the same rising edge; port B last so it wins
  always_ff @(posedge clk) begin
    if (a_cv) begin
      mem[{a_ca, 1'b0}] <= a_d0;
      mem[{a_ca, 1'b1}] <= a_d1;
    end
    if (b_cv) begin
      mem[{b_ca, 1'b0}] <= b_d0;
      mem[{b_ca, 1'b1}] <= b_wdata;
    end
  end

  // read pipelines, array snapshot taken at the command edge
  logic [RD_LAT:0]   ar_v, br_v;
  logic [WORD_W-1:0] ar_d0 [RD_LAT+1];
  logic [WORD_W-1:0] ar_d1 [RD_LAT+1];
  logic [WORD_W-1:0] br_d0 [RD_LAT+1];
  logic [WORD_W-1:0] br_d1 [RD_LAT+1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ar_v <= '0;
    else        ar_v <= {ar_v[RD_LAT-1:0], a_rd};

  always_ff @(posedge clk) begin
    ar_d0[0] <= mem[{a_addr, 1'b0}];
    ar_d1[0] <= mem[{a_addr, 1'b1}];
    for (int i = 1; i <= RD_LAT; i++) begin
      ar_d0[i] <= ar_d0[i-1];
      ar_d1[i] <= ar_d1[i-1];
    end
  end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) br_v <= '0;
    else        br_v <= {br_v[RD_LAT-1:0], b_rd};

  always_ff @(negedge clk) begin
    br_d0[0] <= mem[{b_addr, 1'b0}];
    br_d1[0] <= mem[{b_addr, 1'b1}];
    for (int i = 1; i <= RD_LAT; i++) begin
      br_d0[i] <= br_d0[i-1];
      br_d1[i] <= br_d1[i-1];
    end
  end

  assign a_rvalid = ar_v[RD_LAT];
  assign b_rvalid = br_v[RD_LAT];
  assign a_rdata  = clk ? ar_d0[RD_LAT] : ar_d1[RD_LAT];
  assign b_rdata  = clk ? br_d1[RD_LAT] : br_d0[RD_LAT];
endmodule

module dp_burst_sram_chk #(
  parameter int WORD_W = 18,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 1
) (
  input logic clk,
  input logic rst_n,
  input logic a_ld_n,
  input logic a_rw_n,
  input logic a_rvalid,
  input logic b_ld_n,
  input logic b_rw_n,
  input logic b_rvalid
);
  logic [RD_LAT:0] a_sr, b_sr;

  initial begin
    AST_WIDTH_LEGAL: assert (WORD_W == 18 || WORD_W == 36); // R10
    AST_LAT_LEGAL: assert (RD_LAT >= 1 && WR_LAT >= 1); // R5
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) a_sr <= '0;
    else        a_sr <= {a_sr[RD_LAT-1:0], !a_ld_n && a_rw_n};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) b_sr <= '0;
    else        b_sr <= {b_sr[RD_LAT-1:0], !b_ld_n && b_rw_n};

  AST_A_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n) a_rvalid == a_sr[RD_LAT]); // R3
  AST_B_VALID_TIMING: assert property (@(negedge clk) disable iff (!rst_n) b_rvalid == b_sr[RD_LAT]); // R4
  AST_A_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !a_sr[RD_LAT] |-> !a_rvalid); // R1
  AST_B_IDLE_QUIET: assert property (@(negedge clk) disable iff (!rst_n) !b_sr[RD_LAT] |-> !b_rvalid); // R1
  AST_VALID_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown({a_rvalid, b_rvalid})); // R11
endmodule

bind dp_burst_sram dp_burst_sram_chk #(.WORD_W(WORD_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_ld_n(a_ld_n), .a_rw_n(a_rw_n), .a_rvalid(a_rvalid),
  .b_ld_n(b_ld_n), .b_rw_n(b_rw_n), .b_rvalid(b_rvalid)
);

// File: tb/tb_dp_burst_sram.sv
`timescale 1ns/1ps
module tb_dp_burst_sram;
  localparam int W = 18, AW = 6, RL = 2, WL = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_ld_n = 1'b1, a_rw_n = 1'b1, b_ld_n = 1'b1, b_rw_n = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [W-1:0]  a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_burst_sram #(.WORD_W(W), .ADDR_W(AW), .RD_LAT(RL), .WR_LAT(WL)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_ld_n(a_ld_n), .a_rw_n(a_rw_n), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_ld_n(b_ld_n), .b_rw_n(b_rw_n), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid));

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sync();
    @(negedge clk); #1;
  endtask

  task automatic a_write(input logic [AW-1:0] ad, input logic [W-1:0] w0, input logic [W-1:0] w1);
    @(posedge clk); #1 a_ld_n = 0; a_rw_n = 0; a_addr = ad;
    @(posedge clk); #1 a_ld_n = 1;
    for (int j = 1; j < WL; j++) begin @(posedge clk); #1; end
    a_wdata = w0;
    @(posedge clk); #1 a_wdata = w1;
  endtask

  task automatic b_write(input logic [AW-1:0] ad, input logic [W-1:0] w0, input logic [W-1:0] w1);
    @(negedge clk); #1 b_ld_n = 0; b_rw_n = 0; b_addr = ad;
    @(negedge clk); #1 b_ld_n = 1;
    for (int j = 1; j < WL; j++) begin @(negedge clk); #1; end
    b_wdata = w0;
    @(negedge clk); #1 b_wdata = w1;
    @(posedge clk); #1;
  endtask

  task automatic a_read(input logic [AW-1:0] ad, input logic [W-1:0] e0, input logic [W-1:0] e1, input string req);
    @(posedge clk); #1 a_ld_n = 0; a_rw_n = 1; a_addr = ad;
    @(posedge clk); #1 a_ld_n = 1;
    repeat (RL) @(posedge clk);
    #1 chk(a_rvalid === 1'b1, {req, " A valid"}, a_rvalid, 1);
    chk(a_rdata === e0, {req, " A word0"}, a_rdata, e0);
    @(negedge clk); #1 chk(a_rvalid === 1'b1 && a_rdata === e1, {req, " A word1"}, a_rdata, e1);
    @(posedge clk); #1 chk(a_rvalid === 1'b0, {req, " A valid drop"}, a_rvalid, 0);
  endtask

  task automatic b_read(input logic [AW-1:0] ad, input logic [W-1:0] e0, input logic [W-1:0] e1, input string req);
    @(negedge clk); #1 b_ld_n = 0; b_rw_n = 1; b_addr = ad;
    @(negedge clk); #1 b_ld_n = 1;
    repeat (RL) @(negedge clk);
    #1 chk(b_rvalid === 1'b1, {req, " B valid"}, b_rvalid, 1);
    chk(b_rdata === e0, {req, " B word0"}, b_rdata, e0);
    @(posedge clk); #1 chk(b_rvalid === 1'b1 && b_rdata === e1, {req, " B word1"}, b_rdata, e1);
    @(negedge clk); #1 chk(b_rvalid === 1'b0, {req, " B valid drop"}, b_rvalid, 0);
  endtask

  // R2 R3 R5 R6 R10: single-port writes and reads, full-width patterns
  task automatic t_basic();
    sync(); a_write(6'd3, 18'h3FFFF, 18'h20001);
    sync(); b_write(6'd4, 18'h15555, 18'h2AAAA);
    repeat (3) sync();
    a_read(6'd3, 18'h3FFFF, 18'h20001, "R3 R10");
    b_read(6'd4, 18'h15555, 18'h2AAAA, "R4 R5");
    a_read(6'd4, 18'h15555, 18'h2AAAA, "R6 R2");
    b_read(6'd3, 18'h3FFFF, 18'h20001, "R6");
  endtask

  // R7: all four read/write combinations in one period
  task automatic t_concurrent();
    sync(); fork a_write(6'd10, 18'h0A0A0, 18'h0A0A1); b_write(6'd11, 18'h0B0B0, 18'h0B0B1); join
    repeat (3) sync();
    sync(); fork a_read(6'd11, 18'h0B0B0, 18'h0B0B1, "R7 rr"); b_read(6'd10, 18'h0A0A0, 18'h0A0A1, "R7 rr"); join
    sync(); fork a_read(6'd10, 18'h0A0A0, 18'h0A0A1, "R7 rw"); b_write(6'd12, 18'h0C0C0, 18'h0C0C1); join
    sync(); fork a_write(6'd13, 18'h0D0D0, 18'h0D0D1); b_read(6'd11, 18'h0B0B0, 18'h0B0B1, "R7 wr"); join
    repeat (3) sync();
    sync(); fork a_read(6'd12, 18'h0C0C0, 18'h0C0C1, "R7 b_wr"); b_read(6'd13, 18'h0D0D0, 18'h0D0D1, "R7 a_wr"); join
  endtask

  // R8: same-address writes in one period, port B wins
  task automatic t_write_collide();
    sync(); fork a_write(6'd20, 18'h11111, 18'h11112); b_write(6'd20, 18'h22221, 18'h22222); join
    repeat (3) sync();
    a_read(6'd20, 18'h22221, 18'h22222, "R8");
  endtask

  // R9: read colliding with a write returns old contents
  task automatic t_read_collide();
    sync(); a_write(6'd30, 18'h00300, 18'h00301);
    repeat (3) sync();
    sync(); fork a_write(6'd30, 18'h3F000, 18'h3F001); b_read(6'd30, 18'h00300, 18'h00301, "R9 Bread"); join
    repeat (3) sync();
    sync(); fork a_read(6'd30, 18'h3F000, 18'h3F001, "R9 Aread"); b_write(6'd30, 18'h05050, 18'h05051); join
    repeat (3) sync();
    b_read(6'd30, 18'h05050, 18'h05051, "R9 after");
  endtask

  // R1: strobe high blocks everything
  task automatic t_idle();
    sync(); a_write(6'd40, 18'h04040, 18'h04041);
    repeat (3) sync();
    a_rw_n = 0; a_addr = 6'd40; a_wdata = 18'h3DEAD;
    b_rw_n = 0; b_addr = 6'd40; b_wdata = 18'h3BEEF;
    for (int i = 0; i < 6; i++) begin
      sync();
      chk(a_rvalid === 1'b0 && b_rvalid === 1'b0, "R1 idle valid", {a_rvalid, b_rvalid}, 0);
      if (i == 2) begin a_rw_n = 1; b_rw_n = 1; end
    end
    a_read(6'd40, 18'h04040, 18'h04041, "R1 unchanged");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    #12;
    chk(a_rvalid === 1'b0 && b_rvalid === 1'b0, "R11 reset valid", {a_rvalid, b_rvalid}, 0);
    sync(); rst_n = 1;
    sync();
    chk(a_rvalid === 1'b0 && b_rvalid === 1'b0, "R11 post reset", {a_rvalid, b_rvalid}, 0);
    t_basic();
    t_concurrent();
    t_write_collide();
    t_read_collide();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule